// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide command and status port of a single eight-line interrupt controller. A one-bit address picks between the command register (address 0) and the data register (address 1). A separate select input reaches the per-line edge/level register. The block decodes the initialization word sequence and the operational command words, and it answers register reads. It owns the request, in-service and mask registers, the vector base, the mode flags and the priority rotation offset. It clears in-service bits when end-of-interrupt commands arrive.

Pending-line resolution is done outside the block. An external resolver looks at the exported registers and returns the winning line on `res_valid`/`res_line`. The block uses that answer for acknowledge cycles and for poll reads.

Writes and reads are single-cycle strobes. At most one of `wr_en`, `rd_en` and `inta` is expected in a cycle. Read data is combinational from the current state, and any side effect of a read takes effect on the clock edge that ends its strobe.

Top module: `pic_cmd_port`

## Requirements
- R1: An address-0 command write with bit 4 set starts initialization. It clears the request, in-service, mask and previous-input registers. It zeroes the rotation offset, the vector base, the read select, the poll and all mode flags. It keeps bit 0 as the "mode word follows" flag. It leaves the edge/level register unchanged.
- R2: After an initialization start, address-1 writes are consumed in order:
  - The first write loads the vector base from bits 7:3.
  - The second write is discarded. After it, the port returns to normal mode if the flag is clear, or waits for a mode word if the flag is set.
  - The mode word takes special nesting from bit 4 and auto-EOI from bit 1, then returns to normal mode.
- R3: In normal mode, an address-1 write loads the mask register. An address-1 read returns the mask register.
- R4: An address-0 write with bit 4 clear and bit 3 set is a control word:
  - Bit 2 arms a poll.
  - When bit 1 is set, bit 0 selects the address-0 read source: 1 returns in-service, 0 returns request.
  - When bit 6 is set, bit 5 loads the special-mask flag. When bit 6 is clear, the special-mask flag is unchanged.
- R5: An address-0 write with bits 4 and 3 clear is a command, and bits 7:5 give its code.
  - Code 1 clears the in-service bit of highest priority. Priority starts at line (offset) and falls through lines (offset+1), (offset+2) and onward, modulo 8.
  - Code 5 does the same as code 1, then sets the offset to that line + 1.
- R6: Further command codes:
  - Code 3 clears the in-service bit of the line in bits 2:0.
  - Code 7 clears that same bit and sets the offset to line + 1.
  - Code 6 sets the offset to (bits 2:0 + 1) mod 8.
  - Code 2 has no effect.
  - Codes 0 and 4 set the rotate-on-auto-EOI flag to bit 2 of the code.
- R7: A read while a poll is armed returns the resolver line, or 7 if `res_valid` is low. When `res_valid` is high, the read clears that line's request and in-service bits. The read disarms the poll.
- R8: A write with `elcr_sel` high stores `wdata & LEVEL_MASK` in the edge/level register. A read with `elcr_sel` high returns that register.
- R9: For a line whose edge/level bit is 1, the request bit follows the input. For a line whose bit is 0, a rising input sets the request bit and the bit stays set after the input falls.
- R10: An `inta` pulse with `res_valid` high does three things:
  - It sets the in-service bit of `res_line`.
  - It clears the request bit of that line if the line is edge-triggered.
  - With auto-EOI on, it clears that in-service bit again at once. If rotate-on-auto-EOI is also on, it sets the offset to line + 1.
- R11: After reset, all registers, flags and the offset are zero and the port is in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| elcr_sel | input | 1 | Select the edge/level register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_in | input | 8 | Interrupt request lines |
| res_valid | input | 1 | Resolver has a winning line |
| res_line | input | 3 | Resolver winning line |
| inta | input | 1 | Acknowledge strobe |
| irr | output | 8 | Request register |
| isr | output | 8 | In-service register |
| imr | output | 8 | Mask register |
| elcr | output | 8 | Edge/level register, 1 = level |
| vec_base | output | 5 | Vector base bits 7:3 |
| prio_off | output | 3 | Priority rotation offset |
| spec_mask | output | 1 | Special-mask flag |
| spec_nest | output | 1 | Special nesting flag |
| auto_eoi | output | 1 | Auto-EOI flag |

## Verification
The bench builds the block with `LEVEL_MASK` = 8'hDE, the value for a secondary controller. This makes line 1 selectable as level-sensitive while lines 0 and 5 stay fixed as edge-triggered, so a single run covers both capture behaviours of R9 and both acknowledge variants of R10. Writing all ones to the edge/level register shows that the fixed bits cannot be set. Elaboration with the default 8'hF8 covers the primary controller's mask.

// File: rtl/pic_cmd_port.sv
module pic_cmd_port #(
  parameter logic [7:0] LEVEL_MASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic       elcr_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  input  logic       res_valid,
  input  logic [2:0] res_line,
  input  logic       inta,
  output logic [7:0] irr,
  output logic [7:0] isr,
  output logic [7:0] imr,
  output logic [7:0] elcr,
  output logic [4:0] vec_base,
  output logic [2:0] prio_off,
  output logic       spec_mask,
  output logic       spec_nest,
  output logic       auto_eoi
);

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_SKIP, ST_MODE} init_t;

  init_t      st, st_n;
  logic [7:0] prev, irr_n, isr_n, imr_n, prev_n, elcr_n;
  logic [4:0] base_n;
  logic [2:0] off_n;
  logic       read_isr, rsel_n, poll, poll_n, smm_n, nest_n, aeoi_n;
  logic       rot_aeoi, raeoi_n, need4, need4_n;

  wire       wr_cmd = wr_en && !elcr_sel;
  wire       w0     = wr_cmd && !addr;
  wire       w1     = wr_cmd && addr;
  wire       init_w = w0 && wdata[4];
  wire       ctl_w  = w0 && !wdata[4] && wdata[3];
  wire       eoi_w  = w0 && !wdata[4] && !wdata[3];
  wire [2:0] code   = wdata[7:5];
  wire [2:0] wline  = wdata[2:0];
  wire       poll_rd = rd_en && !elcr_sel && poll;
  wire       ack     = inta && res_valid;

  wire [7:0] rise  = irq_in & ~prev;
  wire [7:0] irr_s = ((irr | rise) & ~elcr) | (irq_in & elcr);

  logic [2:0] isr_top;
  logic       isr_any;
  always_comb begin
    isr_any = 1'b0;
    isr_top = 3'd0;
    for (int k = 7; k >= 0; k--) begin
      if (isr[3'(k) + prio_off]) begin
        isr_any = 1'b1;
        isr_top = 3'(k) + prio_off;
      end
    end
  end

  always_comb begin
    irr_n   = irr_s;
    isr_n   = isr;
    imr_n   = imr;
    prev_n  = irq_in;
    elcr_n  = elcr;
    base_n  = vec_base;
    off_n   = prio_off;
    rsel_n  = read_isr;
    poll_n  = poll;
    smm_n   = spec_mask;
    nest_n  = spec_nest;
    aeoi_n  = auto_eoi;
    raeoi_n = rot_aeoi;
    need4_n = need4;
    st_n    = st;

    if (ack) begin
      isr_n[res_line] = 1'b1;
      if (!elcr[res_line]) irr_n[res_line] = 1'b0;
      if (auto_eoi) begin
        isr_n[res_line] = 1'b0;
        if (rot_aeoi) off_n = res_line + 3'd1;
      end
    end

    if (poll_rd) begin
      poll_n = 1'b0;
      if (res_valid) begin
        irr_n[res_line] = 1'b0;
        isr_n[res_line] = 1'b0;
      end
    end

    if (init_w) begin
      irr_n   = 8'd0;
      isr_n   = 8'd0;
      imr_n   = 8'd0;
      prev_n  = 8'd0;
      off_n   = 3'd0;
      base_n  = 5'd0;
      rsel_n  = 1'b0;
      poll_n  = 1'b0;
      smm_n   = 1'b0;
      nest_n  = 1'b0;
      aeoi_n  = 1'b0;
      raeoi_n = 1'b0;
      need4_n = wdata[0];
      st_n    = ST_BASE;
    end else if (ctl_w) begin
      if (wdata[2]) poll_n = 1'b1;
      if (wdata[1]) rsel_n = wdata[0];
      if (wdata[6]) smm_n  = wdata[5];
    end else if (eoi_w) begin
      case (code)
        3'd0, 3'd4: raeoi_n = code[2];
        3'd1, 3'd5: if (isr_any) begin
          isr_n[isr_top] = 1'b0;
          if (code[2]) off_n = isr_top + 3'd1;
        end
        3'd3: isr_n[wline] = 1'b0;
        3'd6: off_n = wline + 3'd1;
        3'd7: begin
          isr_n[wline] = 1'b0;
          off_n = wline + 3'd1;
        end
        default: ;
      endcase
    end

    if (w1) begin
      case (st)
        ST_RUN:  imr_n = wdata;
        ST_BASE: begin
          base_n = wdata[7:3];
          st_n   = ST_SKIP;
        end
        ST_SKIP: st_n = need4 ? ST_MODE : ST_RUN;
        ST_MODE: begin
          nest_n = wdata[4];
          aeoi_n = wdata[1];
          st_n   = ST_RUN;
        end
        default: st_n = ST_RUN;
      endcase
    end

    if (wr_en && elcr_sel) elcr_n = wdata & LEVEL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr       <= 8'd0;
      isr       <= 8'd0;
      imr       <= 8'd0;
      prev      <= 8'd0;
      elcr      <= 8'd0;
      vec_base  <= 5'd0;
      prio_off  <= 3'd0;
      read_isr  <= 1'b0;
      poll      <= 1'b0;
      spec_mask <= 1'b0;
      spec_nest <= 1'b0;
      auto_eoi  <= 1'b0;
      rot_aeoi  <= 1'b0;
      need4     <= 1'b0;
      st        <= ST_RUN;
    end else begin
      irr       <= irr_n;
      isr       <= isr_n;
      imr       <= imr_n;
      prev      <= prev_n;
      elcr      <= elcr_n;
      vec_base  <= base_n;
      prio_off  <= off_n;
      read_isr  <= rsel_n;
      poll      <= poll_n;
      spec_mask <= smm_n;
      spec_nest <= nest_n;
      auto_eoi  <= aeoi_n;
      rot_aeoi  <= raeoi_n;
      need4     <= need4_n;
      st        <= st_n;
    end
  end

  always_comb begin
    if (elcr_sel)      rdata = elcr;
    else if (poll)     rdata = res_valid ? {5'd0, res_line} : 8'd7;
    else if (addr)     rdata = imr;
    else if (read_isr) rdata = isr;
    else               rdata = irr;
  end

  assert_init_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_w |=> (isr == 8'd0 && imr == 8'd0 && prio_off == 3'd0 && !auto_eoi && !spec_nest));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (w1 && st == ST_RUN) |=> imr == $past(wdata));

  assert_eoi_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_w && code == 3'd1 && isr != 8'd0 && !inta && !rd_en)
      |=> $countones(isr) == $countones($past(isr)) - 1);

  assert_poll_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd |=> !poll);

  assert_elcr_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && elcr_sel) |=> elcr == ($past(wdata) & LEVEL_MASK));

  assert_aeoi_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && auto_eoi && !wr_en && !rd_en) |=> isr == $past(isr));

endmodule

// File: tb/pic_cmd_port_tb.sv
module pic_cmd_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, elcr_sel = 1'b0;
  logic [7:0] wdata = 8'd0, irq_in = 8'd0;
  logic       res_valid = 1'b0, inta = 1'b0;
  logic [2:0] res_line = 3'd0;
  logic [7:0] rdata, irr, isr, imr, elcr;
  logic [4:0] vec_base;
  logic [2:0] prio_off;
  logic       spec_mask, spec_nest, auto_eoi;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cmd_port #(.LEVEL_MASK(8'hDE)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .elcr_sel(elcr_sel), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
    .res_valid(res_valid), .res_line(res_line), .inta(inta),
    .irr(irr), .isr(isr), .imr(imr), .elcr(elcr), .vec_base(vec_base),
    .prio_off(prio_off), .spec_mask(spec_mask), .spec_nest(spec_nest),
    .auto_eoi(auto_eoi));

  // {req[3:0], is_read, addr, sel, data[7:0], exp[7:0]}
  localparam logic [22:0] VEC [0:11] = '{
    {4'd8, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00},  // R8 write all ones
    {4'd8, 1'b1, 1'b0, 1'b1, 8'h00, 8'hDE},  // R8 masked readback
    {4'd3, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h00},  // R3 mask write
    {4'd3, 1'b1, 1'b1, 1'b0, 8'h00, 8'hA5},  // R3 mask read
    {4'd1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h00},  // R1 init, mode word follows
    {4'd1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00},  // R1 mask cleared
    {4'd2, 1'b0, 1'b1, 1'b0, 8'h48, 8'h00},  // R2 base word
    {4'd2, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00},  // R2 discarded word
    {4'd2, 1'b0, 1'b1, 1'b0, 8'h02, 8'h00},  // R2 mode word, auto-EOI
    {4'd2, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h00},  // R2 back in normal mode
    {4'd2, 1'b1, 1'b1, 1'b0, 8'h00, 8'h3C},  // R2 mask took the write
    {4'd1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hDE}   // R1 edge/level kept
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; elcr_sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; elcr_sel = 1'b0;
  endtask

  task automatic rd(input logic a, input logic s, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a; elcr_sel = s;
    #1 chk(rdata, exp, req);
    @(negedge clk);
    rd_en = 1'b0; elcr_sel = 1'b0;
  endtask

  task automatic ack(input logic [2:0] ln);
    @(negedge clk);
    res_valid = 1'b1; res_line = ln; inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(irr, 8'h00, "R11 irr");
    chk(isr, 8'h00, "R11 isr");
    chk(imr, 8'h00, "R11 imr");
    chk({5'd0, prio_off}, 8'h00, "R11 offset");
    chk({5'd0, spec_mask, spec_nest, auto_eoi}, 8'h00, "R11 flags");
    rd(1'b0, 1'b0, 8'h00, "R11 read addr0");

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][18]) rd(VEC[i][17], VEC[i][16], VEC[i][7:0], $sformatf("R%0d table %0d", VEC[i][22:19], i));
      else wr(VEC[i][17], VEC[i][16], VEC[i][15:8]);
    end
    chk({3'd0, vec_base}, 8'h09, "R2 base");
    chk({7'd0, auto_eoi}, 8'h01, "R2 auto-EOI");
    chk({7'd0, spec_nest}, 8'h00, "R2 nesting");

    // R2 three-word init
    wr(1'b0, 1'b0, 8'h10);
    wr(1'b1, 1'b0, 8'h20);
    wr(1'b1, 1'b0, 8'h00);
    wr(1'b1, 1'b0, 8'h77);
    chk(imr, 8'h77, "R2 short init mask");
    chk({3'd0, vec_base}, 8'h04, "R2 short init base");
    chk({7'd0, auto_eoi}, 8'h00, "R1 auto-EOI cleared");
    wr(1'b1, 1'b0, 8'h00);

    // R9 capture
    wr(1'b0, 1'b1, 8'h02);
    set_irq(8'h03);
    chk(irr, 8'h03, "R9 both set");
    set_irq(8'h00);
    chk(irr, 8'h01, "R9 edge holds, level follows");

    // R10 acknowledge
    ack(3'd0);
    chk(isr, 8'h01, "R10 isr set");
    chk(irr, 8'h00, "R10 edge request cleared");
    set_irq(8'h02);
    ack(3'd1);
    chk(isr, 8'h03, "R10 isr level");
    chk(irr, 8'h02, "R10 level request kept");

    // R4 read select
    wr(1'b0, 1'b0, 8'h09);
    rd(1'b0, 1'b0, 8'h02, "R4 select unchanged without bit1");
    wr(1'b0, 1'b0, 8'h0B);
    rd(1'b0, 1'b0, 8'h03, "R4 select in-service");

    // R5 / R6 end-of-interrupt and rotation
    wr(1'b0, 1'b0, 8'h20);
    rd(1'b0, 1'b0, 8'h02, "R5 nonspecific clears line0");
    wr(1'b0, 1'b0, 8'hC3);
    chk({5'd0, prio_off}, 8'h04, "R6 code6 offset");
    ack(3'd5);
    chk(isr, 8'h22, "R10 isr line5");
    wr(1'b0, 1'b0, 8'hA0);
    chk(isr, 8'h02, "R5 rotated priority picks line5");
    chk({5'd0, prio_off}, 8'h06, "R5 code5 offset");
    wr(1'b0, 1'b0, 8'h40);
    chk(isr, 8'h02, "R6 code2 isr");
    chk({5'd0, prio_off}, 8'h06, "R6 code2 offset");
    wr(1'b0, 1'b0, 8'h61);
    chk(isr, 8'h00, "R6 code3 clears line1");
    ack(3'd3);
    wr(1'b0, 1'b0, 8'hE3);
    chk(isr, 8'h00, "R6 code7 clears line3");
    chk({5'd0, prio_off}, 8'h04, "R6 code7 offset");

    // R7 poll
    set_irq(8'h12);
    chk(irr, 8'h12, "R9 line4 edge");
    wr(1'b0, 1'b0, 8'h0C);
    res_valid = 1'b1; res_line = 3'd4;
    rd(1'b1, 1'b0, 8'h04, "R7 poll line");
    chk(irr, 8'h02, "R7 poll clears request");
    rd(1'b1, 1'b0, 8'h00, "R7 poll disarmed");
    wr(1'b0, 1'b0, 8'h0C);
    res_valid = 1'b0;
    rd(1'b0, 1'b0, 8'h07, "R7 poll empty");

    // R4 special mask
    wr(1'b0, 1'b0, 8'h68);
    chk({7'd0, spec_mask}, 8'h01, "R4 special mask on");
    wr(1'b0, 1'b0, 8'h28);
    chk({7'd0, spec_mask}, 8'h01, "R4 special mask kept");
    wr(1'b0, 1'b0, 8'h48);
    chk({7'd0, spec_mask}, 8'h00, "R4 special mask off");

    // R10 auto-EOI with rotation
    wr(1'b0, 1'b0, 8'h11);
    wr(1'b1, 1'b0, 8'h00);
    wr(1'b1, 1'b0, 8'h00);
    wr(1'b1, 1'b0, 8'h12);
    chk({6'd0, spec_nest, auto_eoi}, 8'h03, "R2 nesting and auto-EOI");
    wr(1'b0, 1'b0, 8'h80);
    ack(3'd3);
    chk(isr, 8'h00, "R10 auto-EOI clears");
    chk({5'd0, prio_off}, 8'h04, "R10 rotate on auto-EOI");
    wr(1'b0, 1'b0, 8'h00);
    ack(3'd6);
    chk({5'd0, prio_off}, 8'h04, "R6 code0 stops rotation");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule